// File: doc/BRIEF.md
# Parallel Octal DAC Write Sequencer

This block sits on the host side of an eight-channel, 8-bit converter that shares one parallel data bus among all channels. Each channel is picked by a 3-bit address, and an active-low write strobe loads it. The block takes write requests on a valid/ready handshake. For each request it places the address and the code on the bus pins and then runs the strobe through three intervals: a setup interval, a low pulse and a hold interval. Each interval is a clock-cycle count set by a parameter. The converter's latch is transparent for the whole time the strobe is low, so the block never moves the bus during that phase.

A second form of request, "update all", takes a flat array of eight codes. It writes channels 0 through 7 in ascending order, and each channel gets a full strobe cycle. The block keeps a shadow copy of the last code written to each channel, and that copy can be read back at any time through a channel-select input. The defaults suit a 125 MHz clock: 8 ns per cycle, 15 cycles low (120 ns), 2 cycles of hold (10 ns or more) and 1 cycle of setup before the fall. The 90 ns data setup to the rising edge is covered by the low phase, because the data is already on the bus when the strobe falls.

Top module: `dac_bus_sequencer`

## Requirements
- R1: A synchronous reset drives the strobe high and the address and data outputs to 0, clears all eight shadow codes to 0 and leaves the block ready.
- R2: A single write of channel number k (0 to 7) puts the binary value k on the address pins while the strobe is low. Value 0 is the first channel and value 7 is the last.
- R3: Address and data do not change at any clock edge while the strobe is low, and not at the edge where the strobe rises.
- R4: Each write holds the strobe low for exactly LOW_CYC clock cycles.
- R5: Address and data are stable for at least SETUP_CYC cycles with the strobe high before the strobe falls.
- R6: After the strobe rises, address and data stay unchanged for HOLD_CYC cycles, with the strobe high.
- R7: Ready drops at the edge that accepts a request and stays low for exactly SETUP_CYC+LOW_CYC+HOLD_CYC cycles per channel written. Valid asserted while ready is low starts no write.
- R8: After a write completes, the readback output for that channel shows the written code, and every other channel's readback is unchanged.
- R9: An update-all request (valid with the all flag set) writes channels 0,1,...,7 in that order, the code for channel k taken from bits [8k+7:8k] of the array. There is at least one strobe-high cycle between writes.
- R10: The update-all array is sampled when the request is accepted. Later changes to it, and the single-write channel and code inputs, have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted this cycle if valid |
| reqAll | input | 1 | 1: update all channels from allCodes; 0: single write |
| reqChan | input | 3 | Channel number for a single write |
| reqCode | input | 8 | Code for a single write |
| allCodes | input | 64 | Eight codes, channel k at bits [8k+7:8k] |
| rdChan | input | 3 | Channel selected for readback |
| rdCode | output | 8 | Shadow code of the selected channel |
| busAddr | output | 3 | Converter channel address pins |
| busData | output | 8 | Converter data pins |
| busWrN | output | 1 | Converter write strobe, active low |

## Verification
A wrong phase counter shows up on the next strobe: the low pulse is too short or too long, or the bus moves within the setup or hold window, and the monitor measures each of these at the rising edge. A shadow bank that takes the wrong address or the wrong value appears at the readback output once the strobe has risen. The bench compares all eight channels after each scenario, so a write that reaches a neighbouring channel is caught. A wrong channel counter in update-all mode shows up as an address sequence out of order, or as a busy period that is not eight write cycles long.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_t;

  // Strobes from the sequencer control to the bus datapath.
  typedef struct packed {
    logic loadReq;     // accept: load bus from request
    logic loadNext;    // update-all: advance to next channel
    logic strobeNext;  // strobe is low during the coming cycle
    logic commit;      // rising strobe edge: update shadow
  } seq_ctrl_t;
endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int N_CH      = 8,
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 15,
  parameter int HOLD_CYC  = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqAll,
  output logic      reqReady,
  output seq_ctrl_t ctrl
);
  localparam int MAX_LEN = (SETUP_CYC > LOW_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(N_CH);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic allMode;
  logic phaseEnd;
  logic lastIdx;

  always_comb begin
    case (phase)
      PH_SETUP: phaseEnd = (cnt == CNT_W'(SETUP_CYC - 1));
      PH_LOW:   phaseEnd = (cnt == CNT_W'(LOW_CYC - 1));
      PH_HOLD:  phaseEnd = (cnt == CNT_W'(HOLD_CYC - 1));
      default:  phaseEnd = 1'b0;
    endcase
  end

  assign lastIdx  = (idx == IDX_W'(N_CH - 1));
  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    case (phase)
      PH_IDLE: if (reqValid) begin
        phaseNext    = PH_SETUP;
        ctrl.loadReq = 1'b1;
      end
      PH_SETUP: if (phaseEnd) phaseNext = PH_LOW;
      PH_LOW: if (phaseEnd) begin
        phaseNext   = PH_HOLD;
        ctrl.commit = 1'b1;
      end
      PH_HOLD: if (phaseEnd) begin
        if (allMode && !lastIdx) begin
          phaseNext     = PH_SETUP;
          ctrl.loadNext = 1'b1;
        end else begin
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
    ctrl.strobeNext = (phaseNext == PH_LOW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      allMode <= 1'b0;
    end else begin
      phase <= phaseNext;
      cnt   <= (phaseNext != phase) ? '0 : cnt + CNT_W'(1);
      if (ctrl.loadReq) begin
        allMode <= reqAll;
        idx     <= '0;
      end else if (ctrl.loadNext) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/dac_seq_path.sv
module dac_seq_path
  import dac_seq_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8,
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seq_ctrl_t                ctrl,
  input  logic                     reqAll,
  input  logic [ADDR_W-1:0]        reqChan,
  input  logic [CODE_W-1:0]        reqCode,
  input  logic [N_CH*CODE_W-1:0]   allCodes,
  input  logic [ADDR_W-1:0]        rdChan,
  output logic [CODE_W-1:0]        rdCode,
  output logic [ADDR_W-1:0]        busAddr,
  output logic [CODE_W-1:0]        busData,
  output logic                     busWrN
);
  logic [CODE_W-1:0] shadowQ [N_CH];
  logic [CODE_W-1:0] snapQ   [N_CH];
  logic [ADDR_W-1:0] addrNext;

  assign addrNext = busAddr + ADDR_W'(1);

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    logic [CODE_W-1:0] shReg;
    logic [CODE_W-1:0] snReg;
    always_ff @(posedge clk) begin
      if (rst) begin
        shReg <= '0;
        snReg <= '0;
      end else begin
        if (ctrl.commit && busAddr == ADDR_W'(g)) shReg <= busData;
        if (ctrl.loadReq && reqAll) snReg <= allCodes[g*CODE_W +: CODE_W];
      end
    end
    assign shadowQ[g] = shReg;
    assign snapQ[g]   = snReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr <= '0;
      busData <= '0;
      busWrN  <= 1'b1;
    end else begin
      busWrN <= ~ctrl.strobeNext;
      if (ctrl.loadReq) begin
        if (reqAll) begin
          busAddr <= '0;
          busData <= allCodes[CODE_W-1:0];
        end else begin
          busAddr <= reqChan;
          busData <= reqCode;
        end
      end else if (ctrl.loadNext) begin
        busAddr <= addrNext;
        busData <= snapQ[addrNext];
      end
    end
  end

  assign rdCode = shadowQ[rdChan];
endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer
  import dac_seq_pkg::*;
#(
  parameter int N_CH      = 8,
  parameter int CODE_W    = 8,
  // Cycle counts for a 125 MHz clock (8 ns): 120 ns low -> 15, 10 ns hold -> 2.
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 15,
  parameter int HOLD_CYC  = 2,
  localparam int ADDR_W   = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqAll,
  input  logic [ADDR_W-1:0]      reqChan,
  input  logic [CODE_W-1:0]      reqCode,
  input  logic [N_CH*CODE_W-1:0] allCodes,
  input  logic [ADDR_W-1:0]      rdChan,
  output logic [CODE_W-1:0]      rdCode,
  output logic [ADDR_W-1:0]      busAddr,
  output logic [CODE_W-1:0]      busData,
  output logic                   busWrN
);
  seq_ctrl_t ctrl;

  dac_seq_ctrl #(
    .N_CH(N_CH), .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAll(reqAll),
    .reqReady(reqReady), .ctrl(ctrl)
  );

  dac_seq_path #(.N_CH(N_CH), .CODE_W(CODE_W)) u_path (
    .clk(clk), .rst(rst), .ctrl(ctrl), .reqAll(reqAll), .reqChan(reqChan),
    .reqCode(reqCode), .allCodes(allCodes), .rdChan(rdChan), .rdCode(rdCode),
    .busAddr(busAddr), .busData(busData), .busWrN(busWrN)
  );
endmodule

// File: rtl/dac_bus_sequencer_chk.sv
module dac_bus_sequencer_chk #(
  parameter int N_CH     = 8,
  parameter int CODE_W   = 8,
  parameter int LOW_CYC  = 15,
  localparam int ADDR_W  = $clog2(N_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CODE_W-1:0] busData,
  input logic              busWrN
);
  localparam int LCNT_W = $clog2(LOW_CYC + 1) + 1;
  logic [LCNT_W-1:0] lowCnt;
  logic rstQ;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst || busWrN) lowCnt <= '0;
    else lowCnt <= lowCnt + LCNT_W'(1);
  end

  // R1: outputs right after a reset cycle
  always @(posedge clk) begin
    if (rstQ) begin
      a_r1_reset_values: assert (busWrN && busAddr == '0 && busData == '0 && reqReady);
    end
  end

  a_r3_bus_stable_low: assert property (@(posedge clk) disable iff (rst)
    (!busWrN && !$past(busWrN)) |-> ($stable(busAddr) && $stable(busData)));

  a_r6_bus_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(busWrN) |-> ($stable(busAddr) && $stable(busData)));

  a_r4_low_width: assert property (@(posedge clk) disable iff (rst)
    $rose(busWrN) |-> (lowCnt == LCNT_W'(LOW_CYC)));

  a_r7_busy_while_low: assert property (@(posedge clk) disable iff (rst)
    !busWrN |-> !reqReady);

  a_r9_gap_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busWrN) |=> busWrN);
endmodule

bind dac_bus_sequencer dac_bus_sequencer_chk #(
  .N_CH(N_CH), .CODE_W(CODE_W), .LOW_CYC(LOW_CYC)
) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .busAddr(busAddr),
  .busData(busData), .busWrN(busWrN)
);

// File: tb/dac_bus_sequencer_bench.sv
`timescale 1ns/1ps
module dac_bus_sequencer_bench;
  localparam int S = 1, L = 15, H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqAll = 1'b0;
  logic [2:0] reqChan = '0, rdChan = '0;
  logic [7:0] reqCode = '0;
  logic [63:0] allCodes = '0;
  logic reqReady, busWrN;
  logic [7:0] rdCode, busData;
  logic [2:0] busAddr;

  always #4 clk = ~clk;

  dac_bus_sequencer #(.N_CH(8), .CODE_W(8), .SETUP_CYC(S), .LOW_CYC(L), .HOLD_CYC(H))
  u_dac_bus_sequencer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqAll(reqAll),
    .reqChan(reqChan), .reqCode(reqCode), .allCodes(allCodes), .rdChan(rdChan),
    .rdCode(rdCode), .busAddr(busAddr), .busData(busData), .busWrN(busWrN)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Converter model and bus monitor, sampled on the falling clock edge
  logic [7:0] dacModel [8];
  logic [7:0] expShadow [8];
  int logAddr [64];
  int writeCnt = 0, lowRun = 0, age = 0, sinceRise = 0, highRun = 0, minGap = 1000;
  int setupErr = 0, stableErr = 0, widthErr = 0, holdErr = 0;
  logic prevWrN = 1'b1;
  logic [2:0] prevAddr = '0;
  logic [7:0] prevData = '0;

  always @(negedge clk) begin
    if (rst) begin
      prevWrN = 1'b1; lowRun = 0; age = 0; sinceRise = 100; highRun = 100;
      for (int i = 0; i < 8; i++) dacModel[i] = 8'h00;
    end else begin
      automatic bit changed = (busAddr !== prevAddr) || (busData !== prevData);
      age = changed ? 0 : age + 1;
      if (busWrN == 1'b0) begin
        if (prevWrN == 1'b1) begin
          if (age < S) setupErr++;
          if (highRun < minGap) minGap = highRun;
          lowRun = 1;
        end else begin
          lowRun++;
          if (changed) stableErr++;
        end
      end else begin
        if (prevWrN == 1'b0) begin
          if (lowRun != L) widthErr++;
          if (changed) stableErr++;
          dacModel[busAddr] = busData;
          logAddr[writeCnt] = busAddr;
          writeCnt++;
          sinceRise = 0; highRun = 1;
        end else begin
          sinceRise++; highRun++;
          if (sinceRise < H && changed) holdErr++;
        end
      end
    end
    prevWrN = busWrN; prevAddr = busAddr; prevData = busData;
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_timing_clean(string tag);
    chk("R5", setupErr, 0, {tag, " setup violations"});
    chk("R3", stableErr, 0, {tag, " bus moved in low phase"});
    chk("R4", widthErr, 0, {tag, " low width violations"});
    chk("R6", holdErr, 0, {tag, " hold violations"});
  endtask

  task automatic t_shadows(string tag);
    for (int c = 0; c < 8; c++) begin
      rdChan = 3'(c);
      #1;
      chk("R8", int'(rdCode), int'(expShadow[c]), $sformatf("%s readback ch%0d", tag, c));
      chk("R8", int'(dacModel[c]), int'(expShadow[c]), $sformatf("%s converter ch%0d", tag, c));
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!reqReady) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(busWrN), 1, "strobe after reset");
    chk("R1", int'(busAddr), 0, "address after reset");
    chk("R1", int'(busData), 0, "data after reset");
    chk("R1", int'(reqReady), 1, "ready after reset");
    for (int c = 0; c < 8; c++) begin
      rdChan = 3'(c);
      #1;
      chk("R1", int'(rdCode), 0, $sformatf("shadow ch%0d after reset", c));
      expShadow[c] = 8'h00;
    end
  endtask

  task automatic t_single(int ch, int code);
    int n;
    int wc0 = writeCnt;
    @(negedge clk);
    reqValid = 1'b1; reqAll = 1'b0; reqChan = 3'(ch); reqCode = 8'(code);
    @(negedge clk);
    reqValid = 1'b0;
    wait_idle(n);
    chk("R7", n, S + L + H, $sformatf("busy cycles single ch%0d", ch));
    chk("R7", writeCnt - wc0, 1, "strobe count single");
    chk("R2", logAddr[wc0], ch, "address pins for channel");
    expShadow[ch] = 8'(code);
    t_shadows($sformatf("single ch%0d", ch));
    t_timing_clean("single");
  endtask

  task automatic t_busy_ignore();
    int n;
    int wc0 = writeCnt;
    @(negedge clk);
    reqValid = 1'b1; reqAll = 1'b0; reqChan = 3'd2; reqCode = 8'h5A;
    @(negedge clk);
    reqChan = 3'd6; reqCode = 8'h11;
    for (int i = 0; i < 5; i++) begin
      chk("R7", int'(reqReady), 0, "ready while busy");
      @(negedge clk);
    end
    reqValid = 1'b0;
    wait_idle(n);
    chk("R7", writeCnt - wc0, 1, "valid while busy starts no write");
    expShadow[2] = 8'h5A;
    t_shadows("busy ignore");
    t_timing_clean("busy ignore");
  endtask

  task automatic t_all(logic [63:0] codes);
    int n;
    int wc0 = writeCnt;
    @(negedge clk);
    reqValid = 1'b1; reqAll = 1'b1; allCodes = codes; reqChan = 3'd3; reqCode = 8'hEE;
    @(negedge clk);
    reqValid = 1'b0; reqAll = 1'b0;
    minGap = 1000;
    allCodes = ~codes;  // R10: must not leak into the sequence
    reqCode = 8'h77;
    wait_idle(n);
    chk("R9", n, 8 * (S + L + H), "busy cycles update-all");
    chk("R9", writeCnt - wc0, 8, "strobe count update-all");
    for (int k = 0; k < 8; k++) begin
      chk("R9", logAddr[wc0 + k], k, $sformatf("update-all order slot %0d", k));
      expShadow[k] = codes[k*8 +: 8];
    end
    chk("R9", int'(minGap >= 1), 1, "high gap between writes");
    t_shadows("update-all R10");
    t_timing_clean("update-all");
  endtask

  initial begin
    t_reset();
    t_single(0, 8'h00);
    t_single(7, 8'hFF);
    t_single(3, 8'hA5);
    t_single(0, 8'h80);
    t_busy_ignore();
    t_all(64'h0123_4567_89AB_CDEF);
    t_single(5, 8'h3C);
    t_all(64'hFF00_7F80_0102_FE55);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=idle");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule